// File: doc/BRIEF.md
# SMBus Byte-Command Output Expander

This block is an SMBus slave that turns single-byte bus commands into three latched output levels. These outputs are meant to drive power switches. It samples SCL and SDA with a fast system clock, so no logic runs on the bus clock. It drives SDA as an open-drain line: while `sda_oe` is high, the pad pulls the line low.

A send-byte command writes one data byte into one of two output registers. Bit 7 of the byte picks the register: a run-plane register or a suspend-plane register. A separate asynchronous input, `plane_sel`, picks which of the two registers appears on the outputs. The selection therefore switches with no bus latency.

A receive-byte command returns the live output levels and a thermal flag. The slave address comes from a three-level strap, which is captured once after reset. The slave also answers the SMBus alert response address.

Top module: `smb_expander`

## Requirements
- R1: After reset, `gpo` is 0 with either level on `plane_sel`, `sda_oe` is low, and both output registers hold 0.
- R2: The slave address is taken from `addr_strap` on the first clock after reset and then holds until the next reset. The encodings are 2'b00 (tied low) giving 7'b0100000, 2'b10 (tied high) giving 7'b1001000, and 2'b01 or 2'b11 (floating) giving 7'b0111100.
- R3: The alert response address 7'b0001100 is acknowledged in the same way as the strapped address.
- R4: An address byte whose upper seven bits match neither address gets no acknowledge. The slave then leaves SDA released until the next start condition.
- R5: After a matching address with R/W = 0, the slave acknowledges the address and one data byte. Data bits [2:0] become the new output values. Data bit 7 = 1 writes the suspend-plane register, and bit 7 = 0 writes the run-plane register.
- R6: The written value takes effect on the first SCL rising edge after the data acknowledge, before any stop condition.
- R7: A start or stop condition that arrives before the eighth data bit discards the write, so neither register changes. A start condition also restarts address reception.
- R8: With `plane_sel` = 1, `gpo` shows the run-plane register; with `plane_sel` = 0, `gpo` shows the suspend-plane register. The selection is combinational.
- R9: After a matching address with R/W = 1, the slave acknowledges and sends one byte MSB first. The byte is {thermal flag, 4'b0000, `gpo`[2:0]}, sampled on the SCL falling edge that ends the acknowledge clock.
- R10: After the eighth read bit, the slave releases SDA and drives nothing more until the next start condition.
- R11: `sda_oe` only rises while SCL is low, and it is low on the cycle after a stop condition.
- R12: Data bytes after the first one in a write are not acknowledged and do not change the registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL level seen at the pad |
| sda_i | input | 1 | SDA level seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| addr_strap | input | 2 | Three-level address strap (00 low, 01/11 floating, 10 high) |
| plane_sel | input | 1 | 1 selects the run-plane register, 0 the suspend-plane register |
| therm_i | input | 1 | Thermal shutdown flag returned in read bit 7 |
| gpo | output | OUT_W | Latched output levels |

## Verification
The bench builds the block with its default parameters: two synchronizer stages, three outputs, and the default strap and alert addresses. It clocks the bus at eight system clocks per SCL phase, so the three-cycle lag from synchronizer to event stays inside every phase. This spacing also lets the bench hold SCL high after the data acknowledge and look at `gpo` before sending a stop. The bench re-resets with each strap setting and also moves the strap between resets, which shows that the captured address does not follow the strap pin.

// File: rtl/smbx_pkg.sv
package smbx_pkg;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);

  // strap encodings
  localparam logic [1:0] STRAP_LOW  = 2'b00;
  localparam logic [1:0] STRAP_HIGH = 2'b10;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_END,
    ST_ADDR_ACK,
    ST_WR_DATA,
    ST_WR_END,
    ST_WR_ACK,
    ST_WR_DONE,
    ST_RD_DATA,
    ST_HOLD
  } link_st_e;

endpackage

// File: rtl/smbx_sync.sv
module smbx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_p, sda_p;

  // idle bus reads high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_p <= scl_q[STAGES-1];
      sda_p <= sda_q[STAGES-1];
    end
  end

  assign scl_s    = scl_q[STAGES-1];
  assign sda_s    = sda_q[STAGES-1];
  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/smbx_link.sv
module smbx_link
  import smbx_pkg::*;
#(
  parameter int         OUT_W      = 3,
  parameter logic [6:0] ALERT_ADDR = 7'b0001100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic [6:0]        own_addr,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              sda_oe,
  output logic              wr_en,
  output logic              wr_sel,
  output logic [OUT_W-1:0]  wr_val
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  link_st_e          st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [BYTE_W-1:0] tx_q, tx_d;
  logic              rw_q, rw_d;
  logic              oe_q, oe_d;
  logic              hit;

  assign hit = (sh_q[BYTE_W-1:1] == own_addr) || (sh_q[BYTE_W-1:1] == ALERT_ADDR);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    sh_d  = sh_q;
    tx_d  = tx_q;
    rw_d  = rw_q;
    wr_en = 1'b0;
    if (stop_ev) begin
      st_d = ST_IDLE;
    end else if (start_ev) begin
      st_d  = ST_ADDR;
      cnt_d = '0;
    end else begin
      case (st_q)
        ST_ADDR, ST_WR_DATA: if (scl_rise) begin
          sh_d  = {sh_q[BYTE_W-2:0], sda_s};
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == LAST) st_d = (st_q == ST_ADDR) ? ST_ADDR_END : ST_WR_END;
        end
        ST_ADDR_END: if (scl_fall) begin
          if (hit) begin
            st_d = ST_ADDR_ACK;
            rw_d = sh_q[0];
          end else begin
            st_d = ST_HOLD;
          end
        end
        ST_ADDR_ACK: if (scl_fall) begin
          cnt_d = '0;
          if (rw_q) begin
            st_d = ST_RD_DATA;
            tx_d = tx_byte;
          end else begin
            st_d = ST_WR_DATA;
          end
        end
        ST_WR_END: if (scl_fall) st_d = ST_WR_ACK;
        ST_WR_ACK: if (scl_fall) st_d = ST_WR_DONE;
        ST_WR_DONE: if (scl_rise) begin
          wr_en = 1'b1;
          st_d  = ST_HOLD;
        end
        ST_RD_DATA: if (scl_fall) begin
          tx_d  = {tx_q[BYTE_W-2:0], 1'b0};
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == LAST) st_d = ST_HOLD;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    oe_d = (st_d == ST_ADDR_ACK) || (st_d == ST_WR_ACK) ||
           ((st_d == ST_RD_DATA) && !tx_d[BYTE_W-1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      sh_q  <= '0;
      tx_q  <= '0;
      rw_q  <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
      tx_q  <= tx_d;
      rw_q  <= rw_d;
      oe_q  <= oe_d;
    end
  end

  assign sda_oe = oe_q;
  assign wr_sel = sh_q[BYTE_W-1];
  assign wr_val = sh_q[OUT_W-1:0];

endmodule

// File: rtl/smbx_outbank.sv
module smbx_outbank #(
  parameter int OUT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [OUT_W-1:0] wr_val,
  input  logic             plane_sel,
  output logic [OUT_W-1:0] gpo
);

  logic [OUT_W-1:0] run_q, run_d, sus_q, sus_d;

  always_comb begin
    run_d = run_q;
    sus_d = sus_q;
    if (wr_en) begin
      if (wr_sel) sus_d = wr_val;
      else        run_d = wr_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      sus_q <= '0;
    end else begin
      run_q <= run_d;
      sus_q <= sus_d;
    end
  end

  assign gpo = plane_sel ? run_q : sus_q;

endmodule

// File: rtl/smb_expander.sv
module smb_expander
  import smbx_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         OUT_W       = 3,
  parameter logic [6:0] ADDR_LOW    = 7'b0100000,
  parameter logic [6:0] ADDR_FLOAT  = 7'b0111100,
  parameter logic [6:0] ADDR_HIGH   = 7'b1001000,
  parameter logic [6:0] ADDR_ALERT  = 7'b0001100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  input  logic [1:0]       addr_strap,
  input  logic             plane_sel,
  input  logic             therm_i,
  output logic [OUT_W-1:0] gpo
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_core_n = rst_q[1];

  // strap capture, once per reset
  logic       addr_vld;
  logic [6:0] own_addr, addr_dec;

  always_comb begin
    case (addr_strap)
      STRAP_LOW:  addr_dec = ADDR_LOW;
      STRAP_HIGH: addr_dec = ADDR_HIGH;
      default:    addr_dec = ADDR_FLOAT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      addr_vld <= 1'b0;
      own_addr <= '0;
    end else if (!addr_vld) begin
      addr_vld <= 1'b1;
      own_addr <= addr_dec;
    end
  end

  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic wr_en, wr_sel;
  logic [OUT_W-1:0]  wr_val;
  logic [BYTE_W-1:0] tx_byte;

  assign tx_byte = {therm_i, 7'(gpo)};

  smbx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_core_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  smbx_link #(.OUT_W(OUT_W), .ALERT_ADDR(ADDR_ALERT)) u_link (
    .clk(clk), .rst_n(rst_core_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
    .own_addr(own_addr), .tx_byte(tx_byte), .sda_oe(sda_oe),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_val(wr_val)
  );

  smbx_outbank #(.OUT_W(OUT_W)) u_bank (
    .clk(clk), .rst_n(rst_core_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_val(wr_val), .plane_sel(plane_sel), .gpo(gpo)
  );

endmodule

// File: rtl/smb_expander_chk.sv
module smb_expander_chk #(
  parameter int OUT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             plane_sel,
  input logic [OUT_W-1:0] gpo,
  input logic             wr_en,
  input logic             scl_s,
  input logic             scl_rise,
  input logic             stop_ev,
  input logic             sda_oe,
  input logic             addr_vld,
  input logic [6:0]       own_addr
);

  // R8: outputs move only on a selector change or a committed write
  a_r8_gpo_steady: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(plane_sel) && !$past(wr_en)) |-> $stable(gpo));

  // R6: a write commits only on an SCL rising edge
  a_r6_commit_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> scl_rise);

  // R2: the captured address never moves once valid
  a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_vld && $past(addr_vld)) |-> $stable(own_addr));

  // R11: SDA is pulled only while SCL is low
  a_r11_oe_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  // R11: stop releases the line
  a_r11_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe);

endmodule

bind smb_expander smb_expander_chk #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .plane_sel(plane_sel), .gpo(gpo),
  .wr_en(wr_en), .scl_s(scl_s), .scl_rise(scl_rise), .stop_ev(stop_ev),
  .sda_oe(sda_oe), .addr_vld(addr_vld), .own_addr(own_addr)
);

// File: tb/smb_expander_bench.sv
module smb_expander_bench;

  localparam int H = 8;
  localparam logic [6:0] A_LOW   = 7'b0100000;
  localparam logic [6:0] A_FLOAT = 7'b0111100;
  localparam logic [6:0] A_HIGH  = 7'b1001000;
  localparam logic [6:0] A_ALERT = 7'b0001100;

  // {plane_sel, write byte, expected gpo}
  localparam logic [11:0] VEC [0:6] = '{
    {1'b1, 8'h05, 3'd5},
    {1'b1, 8'h83, 3'd5},
    {1'b0, 8'h06, 3'd3},
    {1'b0, 8'h87, 3'd7},
    {1'b1, 8'hF8, 3'd6},
    {1'b1, 8'h79, 3'd1},
    {1'b0, 8'h00, 3'd0}
  };

  logic clk, rst_n, scl_m, sda_m, plane_sel, therm;
  logic [1:0] strap;
  logic sda_oe;
  logic [2:0] gpo;
  wire sda_bus = sda_m & ~sda_oe;

  int nchk = 0, nfail = 0, viol = 0;
  bit done = 0, prev_oe = 0;

  smb_expander u_smb_expander (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .addr_strap(strap), .plane_sel(plane_sel), .therm_i(therm), .gpo(gpo)
  );

  initial begin
    clk = 1'b0;
    forever #2 clk = ~clk;
  end

  // R11 monitor: pull-down may only begin while SCL is low
  always @(negedge clk) begin
    if (sda_oe && !prev_oe && scl_m) viol++;
    prev_oe = sda_oe;
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(H);
    scl_m = 1'b1; wt(H);
    sda_m = 1'b0; wt(H);
    scl_m = 1'b0; wt(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(H);
    scl_m = 1'b1; wt(H);
    sda_m = 1'b1; wt(H);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b;    wt(H);
    scl_m = 1'b1; wt(H);
    scl_m = 1'b0; wt(H);
  endtask

  // returns 0 on acknowledge
  task automatic send_byte(input logic [7:0] b, output logic nack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; wt(H);
    scl_m = 1'b1; wt(H/2);
    nack = sda_bus; wt(H/2);
    scl_m = 1'b0; wt(H);
  endtask

  task automatic recv_byte(output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(H);
      scl_m = 1'b1; wt(H/2);
      b[i] = sda_bus; wt(H/2);
      scl_m = 1'b0;
    end
    wt(H);
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] d,
                          output logic na, output logic nd);
    bus_start();
    send_byte({a, 1'b0}, na);
    send_byte(d, nd);
    bus_stop();
  endtask

  task automatic do_read(input logic [6:0] a, output logic na, output logic [7:0] d);
    bus_start();
    send_byte({a, 1'b1}, na);
    recv_byte(d);
    send_bit(1'b1);
    bus_stop();
  endtask

  task automatic do_reset(input logic [1:0] s);
    strap = s;
    rst_n = 1'b0; wt(4);
    rst_n = 1'b1; wt(6);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic na, nd, nx;
    logic [7:0] rb;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
    plane_sel = 1'b1; therm = 1'b0; strap = 2'b00;
    wt(3);
    // R1: reset state
    check("R1 gpo in reset", 32'(gpo), 0);
    check("R1 sda_oe in reset", 32'(sda_oe), 0);
    rst_n = 1'b1; wt(6);
    check("R1 gpo run plane", 32'(gpo), 0);
    plane_sel = 1'b0; wt(1);
    check("R1 gpo suspend plane", 32'(gpo), 0);

    // table walk: R5 write targets, R8 mux, R9 read byte
    for (int i = 0; i < 7; i++) begin
      plane_sel = VEC[i][11];
      therm = 1'(i & 1);
      do_write(A_LOW, VEC[i][10:3], na, nd);
      check("R5 write acks", 32'({na, nd}), 0);
      check("R5 R8 gpo after write", 32'(gpo), 32'(VEC[i][2:0]));
      do_read(A_LOW, na, rb);
      check("R9 read ack", 32'(na), 0);
      check("R9 read byte", 32'(rb), 32'({therm, 4'b0000, VEC[i][2:0]}));
    end

    // R8: selector switches outputs at once
    plane_sel = 1'b1;
    do_write(A_LOW, 8'h02, na, nd);
    do_write(A_LOW, 8'h85, na, nd);
    plane_sel = 1'b0; wt(1);
    check("R8 suspend plane shown", 32'(gpo), 5);
    plane_sel = 1'b1; wt(1);
    check("R8 run plane shown", 32'(gpo), 2);

    // R6: commit on the SCL rise after the data acknowledge, before stop
    bus_start();
    send_byte({A_LOW, 1'b0}, na);
    send_byte(8'h04, nd);
    check("R6 not yet committed", 32'(gpo), 2);
    scl_m = 1'b1; wt(H);
    check("R6 committed before stop", 32'(gpo), 4);
    scl_m = 1'b0; wt(H);
    bus_stop();

    // R7: stop before the byte ends discards it
    bus_start();
    send_byte({A_LOW, 1'b0}, na);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bus_stop();
    check("R7 stop abort run plane", 32'(gpo), 4);
    plane_sel = 1'b0; wt(1);
    check("R7 stop abort suspend plane", 32'(gpo), 5);
    plane_sel = 1'b1;
    // R7: restart mid-byte reopens the address phase
    bus_start();
    send_byte({A_LOW, 1'b0}, na);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
    bus_start();
    send_byte({A_LOW, 1'b0}, na);
    send_byte(8'h03, nd);
    bus_stop();
    check("R7 restart acks", 32'({na, nd}), 0);
    check("R7 restart value", 32'(gpo), 3);

    // R4: foreign address ignored
    do_write(7'b0100001, 8'h07, na, nd);
    check("R4 address nack", 32'(na), 1);
    check("R4 data not acked", 32'(nd), 1);
    check("R4 gpo unchanged", 32'(gpo), 3);

    // R12: second data byte neither acked nor applied
    bus_start();
    send_byte({A_LOW, 1'b0}, na);
    send_byte(8'h06, nd);
    send_byte(8'h01, nx);
    bus_stop();
    check("R12 first byte acked", 32'(nd), 0);
    check("R12 extra byte nacked", 32'(nx), 1);
    check("R12 gpo keeps first", 32'(gpo), 6);

    // R3: alert response address, read
    therm = 1'b1;
    do_read(A_ALERT, na, rb);
    check("R3 alert address acked", 32'(na), 0);
    check("R3 R9 alert read byte", 32'(rb), 32'h86);

    // R10: nothing driven after the read byte
    bus_start();
    send_byte({A_LOW, 1'b1}, na);
    recv_byte(rb);
    send_bit(1'b1);
    recv_byte(rb);
    send_bit(1'b1);
    bus_stop();
    check("R10 line released after read", 32'(rb), 32'hFF);

    // R2: strap moves without reset, address holds
    strap = 2'b10; wt(4);
    do_read(A_LOW, na, rb);
    check("R2 old address still acked", 32'(na), 0);
    do_read(A_HIGH, na, rb);
    check("R2 new strap ignored", 32'(na), 1);
    // reset with strap high
    do_reset(2'b10);
    check("R1 gpo after second reset", 32'(gpo), 0);
    plane_sel = 1'b0; wt(1);
    check("R1 suspend reg after second reset", 32'(gpo), 0);
    plane_sel = 1'b1;
    do_read(A_HIGH, na, rb);
    check("R2 strap high address", 32'(na), 0);
    do_read(A_LOW, na, rb);
    check("R2 strap low address dropped", 32'(na), 1);
    do_reset(2'b01);
    do_read(A_FLOAT, na, rb);
    check("R2 strap floating address", 32'(na), 0);
    do_write(A_FLOAT, 8'h07, na, nd);
    check("R2 R5 floating write", 32'(gpo), 7);

    check("R11 pull-down only with SCL low", 32'(viol), 0);
    check("R11 released at end", 32'(sda_oe), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule